// File: doc/BRIEF.md
# Privileged trap return controller

This block keeps the machine status fields of a small hart that runs in machine and user modes, and it executes the two trap-return instructions. Each return names its level with one flag. When the return is allowed, the block pops the interrupt-enable stack of that level and picks the next privilege. It also fetches the resume address from the exception-PC register of that level and asks the core to look at pending interrupts again. A return whose level is above the current privilege is refused with an illegal-instruction strobe, and no state changes.

The same block holds the two exception-PC registers and the interrupt-enable register, which software writes through a simple CSR write port. Writes to an exception-PC register drop the low bits that no aligned PC can hold. Writes to the interrupt-enable register change only the bits that the privilege level encoded in the address may touch. A CSR write that arrives in the same cycle as a return is held back for one cycle, so the return always sees the registers as they stood before that write.

Top module: `trap_return_ctrl`

## Requirements
- R1: After reset, status_out reads 0x1800 (previous-privilege field, bits 12:11, holds 3), priv_out is 3, ie_out and both exception-PC registers are 0, and illegal_trap, irq_recheck and next_pc are 0.
- R2: ret_is_mach=1 requests a return at level 3 and ret_is_mach=0 requests one at level 0. The return is legal when its level is not greater than cur_priv.
- R3: An illegal return raises illegal_trap for exactly the one cycle after the request. It leaves priv_out, status_out and ie_out unchanged, and irq_recheck and next_pc stay 0.
- R4: A legal machine return sets priv_out to the old bits 12:11 of status_out and clears bits 12:11 to 0. It copies bit 7 (previous machine enable) into bit 3 (machine enable) and sets bit 7 to 1.
- R5: A legal user return sets priv_out to 0, copies bit 4 (previous user enable) into bit 0 (user enable) and sets bit 4 to 1. Bits 12:11, 7 and 3 are left as they were.
- R6: In the cycle after a legal return, next_pc holds the exception-PC register of the returning level. That register's CSR address is 0x041 OR (level << 8): 0x041 for user and 0x341 for machine. In every other cycle next_pc is 0.
- R7: A write to address 0x041 or 0x341 stores the data with its low PC_ZERO_BITS bits (default 1) forced to 0.
- R8: A write to address 0x004 | (L << 8) changes only the masked bits of ie_out: mask 0x999 for L=3, mask 0x111 for L=0, and no bits for L=1 or L=2. A write to any other address leaves ie_out unchanged.
- R9: irq_recheck pulses for exactly the one cycle after each legal return and never together with illegal_trap.
- R10: A CSR write in the same cycle as a return request is held for one cycle. The return reads the pre-write register values, ie_out does not change in the cycle right after the return, and the write takes effect one cycle later. Returns that carry a write are spaced at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_req | input | 1 | Trap-return request, one cycle |
| ret_is_mach | input | 1 | 1 = machine return (level 3), 0 = user return (level 0) |
| cur_priv | input | 2 | Current privilege of the hart |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR write address |
| csr_wdata | input | XLEN | CSR write data |
| priv_out | output | 2 | Privilege after the last legal return |
| next_pc | output | XLEN | Resume address, valid with irq_recheck, else 0 |
| status_out | output | XLEN | Status fields (bits 0, 3, 4, 7, 12:11) |
| ie_out | output | XLEN | Interrupt-enable register |
| illegal_trap | output | 1 | Illegal-instruction strobe for a refused return |
| irq_recheck | output | 1 | Request to re-evaluate pending interrupts |

## Verification
A return and a CSR write can fall in the same cycle, and this is the collision that matters. The bench provokes it by raising ret_req together with csr_we aimed at the very exception-PC register that the return reads, and again with a write to the interrupt-enable register. It then judges that next_pc carries the old address, that ie_out holds its old value for one cycle, and that the new values appear one cycle later. Around this, sweeps cover every level and current-privilege pairing, every interrupt-enable address level under several data patterns, and odd exception-PC values.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int ST_W   = 13;
  localparam int UIE_B  = 0;
  localparam int MIE_B  = 3;
  localparam int UPIE_B = 4;
  localparam int MPIE_B = 7;
  localparam int MPP_LO = 11;

  localparam logic [ST_W-1:0] ST_RESET  = 13'h1800;
  localparam logic [11:0]     UEPC_ADDR = 12'h041;
  localparam logic [11:0]     MEPC_ADDR = 12'h341;

  function automatic logic [1:0] ret_level(input logic is_mach);
    return is_mach ? PRIV_M : PRIV_U;
  endfunction

  function automatic logic [11:0] epc_addr(input logic [1:0] lvl);
    return UEPC_ADDR | {2'b00, lvl, 8'h00};
  endfunction

  function automatic logic is_ie_addr(input logic [11:0] a);
    return (a[11:10] == 2'b00) && (a[7:0] == 8'h04);
  endfunction

  function automatic logic [11:0] ie_wmask(input logic [1:0] lvl);
    case (lvl)
      PRIV_M:  return 12'h999;
      PRIV_U:  return 12'h111;
      default: return 12'h000;
    endcase
  endfunction

  function automatic logic [ST_W-1:0] pop_status(input logic [ST_W-1:0] st,
                                                 input logic is_mach);
    logic [ST_W-1:0] n;
    n = st;
    if (is_mach) begin
      n[MIE_B]            = st[MPIE_B];
      n[MPIE_B]           = 1'b1;
      n[MPP_LO+1:MPP_LO]  = PRIV_U;
    end else begin
      n[UIE_B]  = st[UPIE_B];
      n[UPIE_B] = 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/trp_csr_bank.sv
module trp_csr_bank
  import trp_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int PC_ZERO_BITS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_req,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [1:0]      rd_lvl,
  output logic [XLEN-1:0] rd_epc,
  output logic [XLEN-1:0] ie_q,
  output logic            hold_v
);
  localparam logic [XLEN-1:0] PC_MASK =
    {{(XLEN-PC_ZERO_BITS){1'b1}}, {PC_ZERO_BITS{1'b0}}};

  typedef struct packed {
    logic [XLEN-1:0] uepc;
    logic [XLEN-1:0] mepc;
    logic [XLEN-1:0] ie;
  } bank_t;

  function automatic bank_t apply_wr(input bank_t b, input logic v,
                                     input logic [11:0] a,
                                     input logic [XLEN-1:0] d);
    bank_t n;
    logic [XLEN-1:0] m;
    n = b;
    m = {{(XLEN-12){1'b0}}, ie_wmask(a[9:8])};
    if (v) begin
      if (a == epc_addr(PRIV_U)) n.uepc = d & PC_MASK;
      if (a == epc_addr(PRIV_M)) n.mepc = d & PC_MASK;
      if (is_ie_addr(a))         n.ie   = (b.ie & ~m) | (d & m);
    end
    return n;
  endfunction

  bank_t           cur, step, nxt;
  logic [11:0]     hold_addr;
  logic [XLEN-1:0] hold_data;

  always_comb begin
    step = apply_wr(cur, hold_v && !ret_req, hold_addr, hold_data);
    nxt  = apply_wr(step, csr_we && !ret_req, csr_addr, csr_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur       <= '0;
      hold_v    <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      cur <= nxt;
      if (ret_req && csr_we) begin
        hold_v    <= 1'b1;
        hold_addr <= csr_addr;
        hold_data <= csr_wdata;
      end else if (!ret_req) begin
        hold_v <= 1'b0;
      end
    end
  end

  assign rd_epc = (epc_addr(rd_lvl) == MEPC_ADDR) ? cur.mepc : cur.uepc;
  assign ie_q   = cur.ie;
endmodule

// File: rtl/trp_ret_unit.sv
module trp_ret_unit
  import trp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_req,
  input  logic            ret_is_mach,
  input  logic [1:0]      cur_priv,
  input  logic [XLEN-1:0] rd_epc,
  output logic [1:0]      rd_lvl,
  output logic            ret_ok,
  output logic            ret_bad,
  output logic [1:0]      priv_q,
  output logic [XLEN-1:0] status,
  output logic [XLEN-1:0] next_pc,
  output logic            illegal_trap,
  output logic            irq_recheck
);
  logic [ST_W-1:0] st_q;

  assign rd_lvl  = ret_level(ret_is_mach);
  assign ret_bad = ret_req && (rd_lvl > cur_priv);
  assign ret_ok  = ret_req && !ret_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q       <= PRIV_M;
      st_q         <= ST_RESET;
      next_pc      <= '0;
      illegal_trap <= 1'b0;
      irq_recheck  <= 1'b0;
    end else begin
      illegal_trap <= ret_bad;
      irq_recheck  <= ret_ok;
      next_pc      <= ret_ok ? rd_epc : '0;
      if (ret_ok) begin
        priv_q <= ret_is_mach ? st_q[MPP_LO+1:MPP_LO] : PRIV_U;
        st_q   <= pop_status(st_q, ret_is_mach);
      end
    end
  end

  assign status = {{(XLEN-ST_W){1'b0}}, st_q};
endmodule

// File: rtl/trap_return_ctrl.sv
module trap_return_ctrl
  import trp_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int PC_ZERO_BITS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_req,
  input  logic            ret_is_mach,
  input  logic [1:0]      cur_priv,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [1:0]      priv_out,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] status_out,
  output logic [XLEN-1:0] ie_out,
  output logic            illegal_trap,
  output logic            irq_recheck
);
  logic [1:0]      rd_lvl;
  logic [XLEN-1:0] rd_epc;
  logic            ret_ok;
  logic            ret_bad;
  logic            hold_v;

  trp_csr_bank #(.XLEN(XLEN), .PC_ZERO_BITS(PC_ZERO_BITS)) bank_i (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .rd_lvl(rd_lvl),
    .rd_epc(rd_epc), .ie_q(ie_out), .hold_v(hold_v)
  );

  trp_ret_unit #(.XLEN(XLEN)) ret_i (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_is_mach(ret_is_mach),
    .cur_priv(cur_priv), .rd_epc(rd_epc), .rd_lvl(rd_lvl), .ret_ok(ret_ok),
    .ret_bad(ret_bad), .priv_q(priv_out), .status(status_out),
    .next_pc(next_pc), .illegal_trap(illegal_trap), .irq_recheck(irq_recheck)
  );
endmodule

// File: rtl/trp_ret_chk.sv
module trp_ret_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ret_req,
  input logic            ret_is_mach,
  input logic [1:0]      cur_priv,
  input logic            csr_we,
  input logic            ret_ok,
  input logic            ret_bad,
  input logic            hold_v,
  input logic [1:0]      priv_out,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] status_out,
  input logic [XLEN-1:0] ie_out,
  input logic            illegal_trap,
  input logic            irq_recheck
);
  // R2
  mret_low_priv_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && ret_is_mach && cur_priv != 2'd3) |=> (illegal_trap && !irq_recheck));

  // R3
  refused_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_bad |=> ($stable(priv_out) && $stable(status_out) && $stable(ie_out) && next_pc == '0));

  // R4
  mret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_ok && ret_is_mach) |=> (priv_out == $past(status_out[12:11]) &&
      status_out[12:11] == 2'd0 && status_out[7] &&
      status_out[3] == $past(status_out[7])));

  // R5
  uret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_ok && !ret_is_mach) |=> (priv_out == 2'd0 && status_out[4] &&
      status_out[0] == $past(status_out[4])));

  // R6
  idle_pc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_recheck |-> (next_pc == '0));

  // R7
  pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc[0] == 1'b0);

  // R9
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_recheck && illegal_trap));

  // R10
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && csr_we) |=> (hold_v && $stable(ie_out)));
endmodule

bind trap_return_ctrl trp_ret_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_is_mach(ret_is_mach),
  .cur_priv(cur_priv), .csr_we(csr_we), .ret_ok(ret_ok), .ret_bad(ret_bad),
  .hold_v(hold_v), .priv_out(priv_out), .next_pc(next_pc),
  .status_out(status_out), .ie_out(ie_out), .illegal_trap(illegal_trap),
  .irq_recheck(irq_recheck)
);

// File: tb/trap_return_ctrl_test.sv
`timescale 1ns/1ps
module trap_return_ctrl_test;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ret_req = 1'b0;
  logic            ret_is_mach = 1'b0;
  logic [1:0]      cur_priv = 2'd3;
  logic            csr_we = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [1:0]      priv_out;
  logic [XLEN-1:0] next_pc, status_out, ie_out;
  logic            illegal_trap, irq_recheck;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model
  logic [1:0]  m_priv = 2'd3;
  logic [12:0] m_st   = 13'h1800;
  logic [31:0] m_uepc = 0, m_mepc = 0, m_ie = 0;

  always #2.5 clk = ~clk;

  trap_return_ctrl #(.XLEN(XLEN), .PC_ZERO_BITS(1)) uut (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_is_mach(ret_is_mach),
    .cur_priv(cur_priv), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .priv_out(priv_out), .next_pc(next_pc),
    .status_out(status_out), .ie_out(ie_out), .illegal_trap(illegal_trap),
    .irq_recheck(irq_recheck)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ie_mask_of(input int lvl);
    if (lvl == 3) return 32'h0000_0999;
    if (lvl == 0) return 32'h0000_0111;
    return 32'h0;
  endfunction

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
    if (a == 12'h041) m_uepc = d & ~32'h1;
    if (a == 12'h341) m_mepc = d & ~32'h1;
    if (a[11:10] == 0 && a[7:0] == 8'h04)
      m_ie = (m_ie & ~ie_mask_of(int'(a[9:8]))) | (d & ie_mask_of(int'(a[9:8])));
  endtask

  task automatic do_ret(input bit mach, input logic [1:0] cp, input string tag);
    bit          legal;
    logic [31:0] exp_pc;
    legal  = (mach ? 3 : 0) <= int'(cp);
    exp_pc = 0;
    @(negedge clk);
    ret_req = 1'b1; ret_is_mach = mach; cur_priv = cp;
    if (legal) begin
      if (mach) begin
        m_priv = m_st[12:11];
        m_st   = (m_st & ~13'h1888) | (13'(m_st[7]) << 3) | 13'h0080;
        exp_pc = m_mepc;
      end else begin
        m_priv = 2'd0;
        m_st   = (m_st & ~13'h0011) | 13'(m_st[4]) | 13'h0010;
        exp_pc = m_uepc;
      end
    end
    @(negedge clk);
    ret_req = 1'b0;
    chk(illegal_trap == !legal, {tag, " R2 R3 illegal_trap"}, 64'(illegal_trap), 64'(!legal));
    chk(irq_recheck == legal, {tag, " R9 irq_recheck"}, 64'(irq_recheck), 64'(legal));
    chk(next_pc == exp_pc, {tag, " R6 next_pc"}, 64'(next_pc), 64'(exp_pc));
    chk(priv_out == m_priv, {tag, " R4 R5 priv_out"}, 64'(priv_out), 64'(m_priv));
    chk(status_out == 32'(m_st), {tag, " R4 R5 status_out"}, 64'(status_out), 64'(m_st));
    chk(ie_out == m_ie, {tag, " R3 ie_out"}, 64'(ie_out), 64'(m_ie));
    @(negedge clk);
    chk(!illegal_trap && !irq_recheck && next_pc == 0, {tag, " R3 R6 R9 one-cycle strobes"},
        {illegal_trap, irq_recheck, next_pc}, 64'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0; pats[2] = 32'hAAAA_AAAA; pats[3] = 32'h5555_5555;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status_out == 32'h1800, "R1 status_out", 64'(status_out), 64'h1800);
    chk(priv_out == 2'd3, "R1 priv_out", 64'(priv_out), 64'd3);
    chk(ie_out == 0, "R1 ie_out", 64'(ie_out), 0);
    chk(!illegal_trap && !irq_recheck && next_pc == 0, "R1 strobes",
        {illegal_trap, irq_recheck, next_pc}, 0);
    do_ret(1'b0, 2'd3, "R1 uepc reset");

    // R7 exception-PC writes with odd and even values
    for (int i = 0; i < 4; i++) begin
      logic [31:0] v;
      v = 32'h8000_0003 ^ (32'h1357_9BDF * i);
      csr_write(12'h041, v);
      csr_write(12'h341, ~v);
      do_ret(1'b0, 2'd3, "R7 uepc readback");
      do_ret(1'b1, 2'd3, "R7 mepc readback");
    end

    // R2 R3 R4 R5 sweep of level versus current privilege
    for (int cp = 0; cp < 4; cp++)
      for (int f = 0; f < 2; f++)
        do_ret(f[0], cp[1:0], "R2 sweep");

    // R8 interrupt-enable write mask per address level
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 4; p++) begin
        csr_write({2'b00, l[1:0], 8'h04}, pats[p]);
        chk(ie_out == m_ie, "R8 ie mask", 64'(ie_out), 64'(m_ie));
      end
    csr_write(12'h305, 32'hFFFF_FFFF);
    chk(ie_out == m_ie, "R8 other address ignored", 64'(ie_out), 64'(m_ie));

    // R10 collision: return plus write to the register it reads
    csr_write(12'h041, 32'h0000_1000);
    @(negedge clk);
    ret_req = 1'b1; ret_is_mach = 1'b0; cur_priv = 2'd3;
    csr_we = 1'b1; csr_addr = 12'h041; csr_wdata = 32'h0000_2223;
    m_priv = 2'd0;
    m_st   = (m_st & ~13'h0011) | 13'(m_st[4]) | 13'h0010;
    @(negedge clk);
    ret_req = 1'b0; csr_we = 1'b0;
    chk(next_pc == 32'h1000, "R10 return reads old epc", 64'(next_pc), 64'h1000);
    m_uepc = 32'h0000_2222;
    @(negedge clk);
    do_ret(1'b0, 2'd3, "R10 held epc write landed");

    // R10 collision with an interrupt-enable write
    csr_write(12'h304, 32'h0);
    @(negedge clk);
    ret_req = 1'b1; ret_is_mach = 1'b0; cur_priv = 2'd0;
    csr_we = 1'b1; csr_addr = 12'h304; csr_wdata = 32'hFFFF_FFFF;
    m_priv = 2'd0;
    m_st   = (m_st & ~13'h0011) | 13'(m_st[4]) | 13'h0010;
    @(negedge clk);
    ret_req = 1'b0; csr_we = 1'b0;
    chk(ie_out == 32'h0, "R10 ie held back", 64'(ie_out), 0);
    chk(irq_recheck == 1'b1, "R9 R10 recheck on collide", 64'(irq_recheck), 1);
    @(negedge clk);
    chk(ie_out == 32'h999, "R10 ie applied next cycle", 64'(ie_out), 64'h999);
    m_ie = 32'h999;
    chk(status_out == 32'(m_st), "R5 status after collide", 64'(status_out), 64'(m_st));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule